// File: doc/BRIEF.md
# Power Domain Sequencer with Idle Handshake

This block sequences four switchable power domains from a small register port. Software requests a domain off or on by writing a control bit. The block then drives that domain's power-switch enable and reports the new state in a status register. The status changes only after a programmable number of clock cycles has elapsed. Power-down, power-up, core-group domains and the graphics-group domain each have their own count register.

Before a domain may lose power, its bus interface must be quiesced. Software sets the domain's idle request bit, and a per-domain responder model answers with an acknowledge and then an idle flag. The sequencer refuses to remove power until that idle flag is present. The intended order for power-off is: set the idle request, wait for the acknowledge and the idle flag, then request power off. For power-on the order is: request power on, wait for the status to show on, then clear the idle request.

Top module: `pd_sequencer`

## Requirements
- R1: After reset the control (0x08), idle request (0x10) and idle/acknowledge (0x14) registers read 0. The status register (0x0C) reads 0, which means every domain is powered. All four count registers (0x34, 0x38, 0x3C, 0x40) read 24, and every `dom_pwr_en` bit is 1.
- R2: Domains 0..3 use control bits 7, 14, 8, 9, status bits 7, 10, 8, 9 and idle request bits 4, 9, 3, 2. In register 0x14 each domain's idle flag sits at its request bit index and its acknowledge sits 16 positions higher. The count registers hold the low 16 bits of the written value. All other bits read 0, the status register ignores writes, and unmapped addresses read 0.
- R3: A domain whose control bit is 1 keeps `dom_pwr_en` at 1 and its status at 0 while its idle flag is clear. Once the idle flag sets, the switch drops at the next clock edge.
- R4: When a domain powers off with its idle flag already set, its `dom_pwr_en` bit falls at the first clock edge after the control write. Its status bit becomes 1 exactly N edges later, where N is the group's power-down count.
- R5: Writing a control bit to 0 for an off domain raises its `dom_pwr_en` bit at the first edge after the write. The status bit returns to 0 exactly N edges later, where N is the group's power-up count.
- R6: Domain 3 times its transitions from the graphics counts (down 0x3C, up 0x40). Domains 0 to 2 use the core counts (down 0x34, up 0x38).
- R7: A domain's acknowledge rises 2 edges after its request bit is written to 1, and its idle flag rises 1 edge after that. Both fall with the same latencies after the request is written to 0.
- R8: Writing a control value equal to a domain's present state leaves `dom_pwr_en`, status and the idle/acknowledge bits unchanged.
- R9: A count of 0 acts as 1, so the status follows the switch one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| dom_pwr_en | output | 4 | Power-switch enable per domain, 1 = powered |

## Verification
A domain controller stuck in a counting or off state shows up at `dom_pwr_en` one edge after the control write that should have moved it. A wrong counter load shows up as a status bit that flips one or more cycles early or late against the programmed count. A responder with wrong delays shows up in register 0x14 within three cycles of the request write. A missing idle gate lets the switch drop while the idle flag is still clear, and this appears at the port on the first edge after the control write.

// File: rtl/pds_pkg.sv
`timescale 1ns/1ps
package pds_pkg;
   localparam int PDS_MAX_DOM = 4;
   localparam int ACK_OFS     = 16;

   typedef int unsigned bitpos_t [PDS_MAX_DOM];

   // per-domain bit positions inside the shared registers
   localparam bitpos_t PWR_BIT  = '{7, 14, 8, 9};
   localparam bitpos_t STAT_BIT = '{7, 10, 8, 9};
   localparam bitpos_t REQ_BIT  = '{4, 9, 3, 2};

   // domains timed by the graphics count pair
   localparam logic [PDS_MAX_DOM-1:0] GFX_GROUP = 4'b1000;

   localparam int ADR_CTRL    = 'h08;
   localparam int ADR_STAT    = 'h0C;
   localparam int ADR_REQ     = 'h10;
   localparam int ADR_IDLE    = 'h14;
   localparam int ADR_CORE_DN = 'h34;
   localparam int ADR_CORE_UP = 'h38;
   localparam int ADR_GFX_DN  = 'h3C;
   localparam int ADR_GFX_UP  = 'h40;

   typedef enum logic [1:0] {DS_ON, DS_DOWN, DS_OFF, DS_UP} dom_state_e;
endpackage

// File: rtl/pds_idle_resp.sv
`timescale 1ns/1ps
module pds_idle_resp #(
   parameter int ACK_DLY  = 2,
   parameter int IDLE_DLY = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic ack,
   output logic idle
);
   localparam int CHAIN = ACK_DLY + IDLE_DLY;

   if (ACK_DLY < 1 || IDLE_DLY < 1) begin : g_bad_dly
      $error("pds_idle_resp: both delays must be at least 1");
   end

   logic [CHAIN-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[CHAIN-2:0], req};
   end

   assign ack  = pipe[ACK_DLY-1];
   assign idle = pipe[CHAIN-1];
endmodule

// File: rtl/pds_dom_ctrl.sv
`timescale 1ns/1ps
module pds_dom_ctrl
   import pds_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             off_req,
   input  logic             idle_ok,
   input  logic [CNT_W-1:0] dn_cnt,
   input  logic [CNT_W-1:0] up_cnt,
   output logic             sw_on,
   output logic             stat_off
);
   dom_state_e       st;
   logic [CNT_W-1:0] cnt;

   // a count of N lets status follow the switch after N edges; 0 acts as 1
   function automatic logic [CNT_W-1:0] load_val(input logic [CNT_W-1:0] n);
      return (n == '0) ? '0 : n - CNT_W'(1);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= DS_ON;
         cnt      <= '0;
         sw_on    <= 1'b1;
         stat_off <= 1'b0;
      end else begin
         case (st)
            DS_ON: if (off_req && idle_ok) begin
               st    <= DS_DOWN;
               sw_on <= 1'b0;
               cnt   <= load_val(dn_cnt);
            end
            DS_DOWN: if (cnt == '0) begin
               st       <= DS_OFF;
               stat_off <= 1'b1;
            end else cnt <= cnt - CNT_W'(1);
            DS_OFF: if (!off_req) begin
               st    <= DS_UP;
               sw_on <= 1'b1;
               cnt   <= load_val(up_cnt);
            end
            DS_UP: if (cnt == '0) begin
               st       <= DS_ON;
               stat_off <= 1'b0;
            end else cnt <= cnt - CNT_W'(1);
            default: st <= DS_ON;
         endcase
      end
   end
endmodule

// File: rtl/pd_sequencer.sv
`timescale 1ns/1ps
module pd_sequencer
   import pds_pkg::*;
#(
   parameter int NUM_DOM  = 4,
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter int CNT_W    = 16,
   parameter int DEF_CNT  = 24,
   parameter int ACK_DLY  = 2,
   parameter int IDLE_DLY = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic [NUM_DOM-1:0] dom_pwr_en
);
   localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(ADR_CTRL);
   localparam logic [ADDR_W-1:0] A_STAT    = ADDR_W'(ADR_STAT);
   localparam logic [ADDR_W-1:0] A_REQ     = ADDR_W'(ADR_REQ);
   localparam logic [ADDR_W-1:0] A_IDLE    = ADDR_W'(ADR_IDLE);
   localparam logic [ADDR_W-1:0] A_CORE_DN = ADDR_W'(ADR_CORE_DN);
   localparam logic [ADDR_W-1:0] A_CORE_UP = ADDR_W'(ADR_CORE_UP);
   localparam logic [ADDR_W-1:0] A_GFX_DN  = ADDR_W'(ADR_GFX_DN);
   localparam logic [ADDR_W-1:0] A_GFX_UP  = ADDR_W'(ADR_GFX_UP);
   localparam logic [CNT_W-1:0]  CNT_RST   = CNT_W'(DEF_CNT);

   if (NUM_DOM < 1 || NUM_DOM > PDS_MAX_DOM) begin : g_bad_dom
      $error("pd_sequencer: NUM_DOM out of range");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("pd_sequencer: ADDR_W too small for the register map");
   end
   if (DATA_W < ACK_OFS + 10 || CNT_W > DATA_W || CNT_W < 1) begin : g_bad_data
      $error("pd_sequencer: DATA_W or CNT_W unsuitable");
   end
   if ((longint'(DEF_CNT) >> CNT_W) != 0) begin : g_bad_def
      $error("pd_sequencer: DEF_CNT does not fit CNT_W");
   end

   logic [NUM_DOM-1:0] ctrl_q, req_q, ack_w, idle_w, stat_off;
   logic [CNT_W-1:0]   cnt_core_dn, cnt_core_up, cnt_gfx_dn, cnt_gfx_up;
   logic               wdata_unused;

   assign wdata_unused = ^reg_wdata;

   // register writes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q      <= '0;
         req_q       <= '0;
         cnt_core_dn <= CNT_RST;
         cnt_core_up <= CNT_RST;
         cnt_gfx_dn  <= CNT_RST;
         cnt_gfx_up  <= CNT_RST;
      end else if (reg_wr) begin
         case (reg_addr)
            A_CTRL: for (int d = 0; d < NUM_DOM; d++) ctrl_q[d] <= reg_wdata[PWR_BIT[d]];
            A_REQ:  for (int d = 0; d < NUM_DOM; d++) req_q[d]  <= reg_wdata[REQ_BIT[d]];
            A_CORE_DN: cnt_core_dn <= reg_wdata[CNT_W-1:0];
            A_CORE_UP: cnt_core_up <= reg_wdata[CNT_W-1:0];
            A_GFX_DN:  cnt_gfx_dn  <= reg_wdata[CNT_W-1:0];
            A_GFX_UP:  cnt_gfx_up  <= reg_wdata[CNT_W-1:0];
            default: ;
         endcase
      end
   end

   // register reads
   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CTRL: for (int d = 0; d < NUM_DOM; d++) reg_rdata[PWR_BIT[d]]  = ctrl_q[d];
         A_STAT: for (int d = 0; d < NUM_DOM; d++) reg_rdata[STAT_BIT[d]] = stat_off[d];
         A_REQ:  for (int d = 0; d < NUM_DOM; d++) reg_rdata[REQ_BIT[d]]  = req_q[d];
         A_IDLE: for (int d = 0; d < NUM_DOM; d++) begin
            reg_rdata[REQ_BIT[d]]           = idle_w[d];
            reg_rdata[REQ_BIT[d] + ACK_OFS] = ack_w[d];
         end
         A_CORE_DN: reg_rdata[CNT_W-1:0] = cnt_core_dn;
         A_CORE_UP: reg_rdata[CNT_W-1:0] = cnt_core_up;
         A_GFX_DN:  reg_rdata[CNT_W-1:0] = cnt_gfx_dn;
         A_GFX_UP:  reg_rdata[CNT_W-1:0] = cnt_gfx_up;
         default: ;
      endcase
   end

   // one responder and one sequencer per domain
   for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
      logic [CNT_W-1:0] dn_sel, up_sel;

      if (GFX_GROUP[d]) begin : g_gfx
         assign dn_sel = cnt_gfx_dn;
         assign up_sel = cnt_gfx_up;
      end else begin : g_core
         assign dn_sel = cnt_core_dn;
         assign up_sel = cnt_core_up;
      end

      pds_idle_resp #(.ACK_DLY(ACK_DLY), .IDLE_DLY(IDLE_DLY)) u_resp (
         .clk  (clk),
         .rst_n(rst_n),
         .req  (req_q[d]),
         .ack  (ack_w[d]),
         .idle (idle_w[d])
      );

      pds_dom_ctrl #(.CNT_W(CNT_W)) u_ctrl (
         .clk     (clk),
         .rst_n   (rst_n),
         .off_req (ctrl_q[d]),
         .idle_ok (idle_w[d]),
         .dn_cnt  (dn_sel),
         .up_cnt  (up_sel),
         .sw_on   (dom_pwr_en[d]),
         .stat_off(stat_off[d])
      );
   end
endmodule

// File: rtl/pd_sequencer_chk.sv
`timescale 1ns/1ps
module pd_sequencer_chk #(
   parameter int ND      = 4,
   parameter int ACK_DLY = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic [ND-1:0] sw_on,
   input logic [ND-1:0] stat_off,
   input logic [ND-1:0] req,
   input logic [ND-1:0] ack,
   input logic [ND-1:0] idle
);
   for (genvar d = 0; d < ND; d++) begin : g_chk
      // R3: power is removed only while the idle flag was present
      p_off_needs_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(sw_on[d]) |-> $past(idle[d]));

      // R4: status still reads on when the switch opens
      p_off_stat_lag_r4: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(sw_on[d]) |-> !stat_off[d]);

      // R4: status reports off only with the switch open
      p_stat_off_sw_r4: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(stat_off[d]) |-> !sw_on[d]);

      // R5: status still reads off when the switch closes
      p_on_stat_lag_r5: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(sw_on[d]) |-> stat_off[d]);

      // R5: status reports on only with the switch closed
      p_stat_on_sw_r5: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(stat_off[d]) |-> sw_on[d]);

      // R7: acknowledge follows the request with the fixed latency
      p_ack_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ack[d]) |-> $past(req[d], ACK_DLY));

      p_ack_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(ack[d]) |-> !$past(req[d], ACK_DLY));

      // R7: idle never rises ahead of the acknowledge
      p_idle_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(idle[d]) |-> $past(ack[d]));
   end
endmodule

bind pd_sequencer pd_sequencer_chk #(.ND(NUM_DOM), .ACK_DLY(ACK_DLY)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .sw_on   (dom_pwr_en),
   .stat_off(stat_off),
   .req     (req_q),
   .ack     (ack_w),
   .idle    (idle_w)
);

// File: tb/pd_sequencer_bench.sv
`timescale 1ns/1ps
module pd_sequencer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [3:0]  pwr_en;
   int          n_tests = 0;
   int          n_fail  = 0;
   bit          done    = 1'b0;

   always #2.5 clk = ~clk;

   pd_sequencer u_pd_sequencer (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .dom_pwr_en(pwr_en)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic expect_reg(input string tag, input logic [7:0] a, input logic [31:0] exp);
      reg_addr = a;
      #0.5;
      check(tag, reg_rdata, exp);
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      expect_reg("R1 ctrl", 8'h08, 32'h0);
      expect_reg("R1 status", 8'h0C, 32'h0);
      expect_reg("R1 req", 8'h10, 32'h0);
      expect_reg("R1 idle/ack", 8'h14, 32'h0);
      expect_reg("R1 core dn", 8'h34, 32'd24);
      expect_reg("R1 core up", 8'h38, 32'd24);
      expect_reg("R1 gfx dn", 8'h3C, 32'd24);
      expect_reg("R1 gfx up", 8'h40, 32'd24);
      check("R1 switches", {28'h0, pwr_en}, 32'hF);
   endtask

   task automatic t_regmap;
      wr(8'h08, 32'hFFFF_FFFF);
      expect_reg("R2 ctrl bits", 8'h08, 32'h0000_4380);
      cycles(4);
      check("R3 no idle keeps power", {28'h0, pwr_en}, 32'hF);
      expect_reg("R3 no idle keeps status", 8'h0C, 32'h0);
      wr(8'h08, 32'h0);
      wr(8'h0C, 32'hFFFF_FFFF);
      expect_reg("R2 status read-only", 8'h0C, 32'h0);
      wr(8'h10, 32'hFFFF_FFFF);
      expect_reg("R2 req bits", 8'h10, 32'h0000_021C);
      cycles(3);
      expect_reg("R2 idle/ack bits", 8'h14, 32'h021C_021C);
      wr(8'h10, 32'h0);
      cycles(3);
      expect_reg("R2 idle/ack clear", 8'h14, 32'h0);
      wr(8'h34, 32'h0001_2345);
      expect_reg("R2 count width", 8'h34, 32'h0000_2345);
      expect_reg("R2 unmapped", 8'h20, 32'h0);
   endtask

   task automatic t_handshake;
      wr(8'h10, 32'h200);
      expect_reg("R7 rise +0", 8'h14, 32'h0);
      cycles(1);
      expect_reg("R7 rise +1", 8'h14, 32'h0);
      cycles(1);
      expect_reg("R7 ack +2", 8'h14, 32'h0200_0000);
      cycles(1);
      expect_reg("R7 idle +3", 8'h14, 32'h0200_0200);
      wr(8'h10, 32'h0);
      cycles(1);
      expect_reg("R7 fall +1", 8'h14, 32'h0200_0200);
      cycles(1);
      expect_reg("R7 ack fall +2", 8'h14, 32'h0000_0200);
      cycles(1);
      expect_reg("R7 idle fall +3", 8'h14, 32'h0);
   endtask

   task automatic t_gate;
      wr(8'h34, 32'd5);
      wr(8'h38, 32'd3);
      wr(8'h08, 32'h100);
      cycles(8);
      check("R3 held on without idle", {31'h0, pwr_en[2]}, 32'h1);
      expect_reg("R3 status on without idle", 8'h0C, 32'h0);
      wr(8'h10, 32'h8);
      cycles(3);
      check("R3 on until idle seen", {31'h0, pwr_en[2]}, 32'h1);
      cycles(1);
      check("R3 off after idle", {31'h0, pwr_en[2]}, 32'h0);
      cycles(4);
      expect_reg("R4 status before count", 8'h0C, 32'h0);
      cycles(1);
      expect_reg("R4 status after count", 8'h0C, 32'h100);
      wr(8'h08, 32'h0);
      cycles(5);
      check("R5 restore", {28'h0, pwr_en}, 32'hF);
      expect_reg("R5 restore status", 8'h0C, 32'h0);
      wr(8'h10, 32'h0);
      cycles(3);
   endtask

   task automatic t_power_off;
      wr(8'h10, 32'h10);
      cycles(3);
      wr(8'h08, 32'h80);
      check("R4 switch before edge", {31'h0, pwr_en[0]}, 32'h1);
      cycles(1);
      check("R4 switch off", {31'h0, pwr_en[0]}, 32'h0);
      expect_reg("R4 status lags", 8'h0C, 32'h0);
      cycles(4);
      expect_reg("R4 status at N-1", 8'h0C, 32'h0);
      cycles(1);
      expect_reg("R4 status at N", 8'h0C, 32'h80);
   endtask

   task automatic t_power_on;
      wr(8'h08, 32'h0);
      check("R5 switch before edge", {31'h0, pwr_en[0]}, 32'h0);
      cycles(1);
      check("R5 switch on", {31'h0, pwr_en[0]}, 32'h1);
      expect_reg("R5 status lags", 8'h0C, 32'h80);
      cycles(2);
      expect_reg("R5 status at N-1", 8'h0C, 32'h80);
      cycles(1);
      expect_reg("R5 status at N", 8'h0C, 32'h0);
      wr(8'h10, 32'h0);
      cycles(3);
      expect_reg("R7 released", 8'h14, 32'h0);
   endtask

   task automatic t_group;
      wr(8'h3C, 32'd3);
      wr(8'h40, 32'd0);
      wr(8'h34, 32'd7);
      wr(8'h10, 32'h4);
      cycles(3);
      wr(8'h08, 32'h200);
      check("R6 switch before edge", {31'h0, pwr_en[3]}, 32'h1);
      cycles(1);
      check("R6 switch off", {31'h0, pwr_en[3]}, 32'h0);
      cycles(2);
      expect_reg("R6 status at gfx N-1", 8'h0C, 32'h0);
      cycles(1);
      expect_reg("R6 status at gfx N", 8'h0C, 32'h200);
   endtask

   task automatic t_same_state;
      expect_reg("R8 idle/ack before", 8'h14, 32'h0004_0004);
      wr(8'h08, 32'h200);
      cycles(6);
      check("R8 switches unchanged", {28'h0, pwr_en}, 32'h7);
      expect_reg("R8 status unchanged", 8'h0C, 32'h200);
      expect_reg("R8 idle/ack unchanged", 8'h14, 32'h0004_0004);
   endtask

   task automatic t_zero_cnt;
      wr(8'h08, 32'h0);
      check("R9 still off at write", {31'h0, pwr_en[3]}, 32'h0);
      cycles(1);
      check("R9 switch on", {31'h0, pwr_en[3]}, 32'h1);
      expect_reg("R9 status lags one", 8'h0C, 32'h200);
      cycles(1);
      expect_reg("R9 status on after one", 8'h0C, 32'h0);
      wr(8'h10, 32'h0);
      cycles(3);
      wr(8'h08, 32'h0);
      cycles(5);
      check("R8 on-request when on", {28'h0, pwr_en}, 32'hF);
      expect_reg("R8 status when on", 8'h0C, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regmap();
      t_handshake();
      t_gate();
      t_power_off();
      t_power_on();
      t_group();
      t_same_state();
      t_zero_cnt();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule